// File: doc/BRIEF.md
# Orbit-Framed Dual-Channel Word Formatter

This block merges the per-clock samples of two charge-digitizer channels into one 18-bit word stream for a serial link transmitter. Each channel sample is a 2-bit exponent, a 5-bit mantissa and a 2-bit capacitor ID. A bunch-crossing-zero strobe marks the start of each orbit. On that strobe the block emits a header word, and for the same cycle it pulses a reset to both digitizers. A fixed run of all-ones fill words follows. After that, one packed data word is sent per clock until the next strobe.

A 12-bit bunch counter runs beside the stream. On each strobe it reports the count it has reached, checks that count against the expected last slot of the orbit, and restarts at zero. Each channel passes through its own selectable delay line of 0 to `MAX_DLY` clocks, so that channels with different cable or clock skews line up before packing. The aligned capacitor IDs are checked for agreement between the two channels. The ID of channel A is also checked for the 0,1,2,3 cycle. Errors are held until the next header reports them.

Top module: `orbit_formatter`

## Requirements
- R1: After reset and until the first strobe, `tx_send_o` is 0, `tx_data_o` is 0 and `dig_rst_o` is 0.
- R2: One cycle after `bc0_i` is sampled high, `tx_send_o` and `dig_rst_o` are 1 and `tx_data_o` is a header. Bit 17 is the capacitor-ID error flag, bit 16 is the bunch-count error flag, bits 15:12 are 0, and bits 11:0 hold the bunch count reached just before the restart. `dig_rst_o` is 0 in every other cycle.
- R3: The `FILL_LEN` words after a header (slots 1 to `FILL_LEN`) are all ones (0x3FFFF).
- R4: From slot `FILL_LEN`+1 onward, each word is a data word with this layout: channel A exponent in [17:16], mantissa in [15:11] and capacitor ID in [10:9]; channel B exponent in [8:7], mantissa in [6:2] and capacitor ID in [1:0].
- R5: `a_dly_i` and `b_dly_i` (0 to `MAX_DLY`) delay their channel by that many clocks before packing. The data word in a slot holds the channel's input from that many cycles earlier.
- R6: The bunch counter restarts at 0 on each strobe and increments on every other clock. On a strobe other than the first after reset, the bunch-count flag is set when the count differs from `ORBIT_LEN`-1. It is never set on the first strobe after reset.
- R7: When the two aligned capacitor IDs differ, the capacitor-ID flag is set.
- R8: When the aligned channel-A capacitor ID is not its previous value plus 1 (mod 4), the capacitor-ID flag is set.
- R9: The capacitor-ID checks are inactive before the first strobe. They are also inactive for `MAX_DLY`+1 clocks after each strobe.
- R10: The capacitor-ID flag is sticky. It is reported in the next header and then cleared. An error detected in the strobe cycle itself goes into that strobe's header.
- R11: After the first strobe, `tx_send_o` stays 1 on every cycle. When no strobe arrives after slot `ORBIT_LEN`-1, data words continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bc0_i | input | 1 | Bunch-crossing-zero strobe, starts an orbit |
| a_exp_i | input | 2 | Channel A exponent |
| a_mant_i | input | 5 | Channel A mantissa |
| a_cap_i | input | 2 | Channel A capacitor ID |
| b_exp_i | input | 2 | Channel B exponent |
| b_mant_i | input | 5 | Channel B mantissa |
| b_cap_i | input | 2 | Channel B capacitor ID |
| a_dly_i | input | SEL_W | Channel A alignment delay select |
| b_dly_i | input | SEL_W | Channel B alignment delay select |
| tx_data_o | output | 18 | Output word (header, fill or data) |
| tx_send_o | output | 1 | Word-valid strobe to the serializer |
| dig_rst_o | output | 1 | Reset pulse to both digitizers |

## Verification
Most internal faults show at the ports one cycle later, as a word of the wrong kind in a slot. For example, a fill word where data is expected, a misplaced header, or a data word that carries a sample from the wrong delay tap. Faults in the bunch counter or in the capacitor-ID error tracking show up only in the next header word, which can be up to a whole orbit later. For that reason, orbits are run end to end, and each header is compared with the count and flags worked out from the injected orbit length and ID corruptions. A sweep over all delay pairs, using streams whose skew matches the selected delays, shows a misaligned tap either as a wrong data word or as a spurious ID flag.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;

    localparam int EXP_W   = 2;
    localparam int MANT_W  = 5;
    localparam int CAP_W   = 2;
    localparam int BCN_W   = 12;
    localparam int SPARE_W = 4;
    localparam int SMP_W   = EXP_W + MANT_W + CAP_W;
    localparam int WORD_W  = 2 * SMP_W;

    typedef struct packed {
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
        logic [CAP_W-1:0]  cap;
    } sample_t;

    typedef struct packed {
        logic               cap_err;
        logic               bcn_err;
        logic [SPARE_W-1:0] spare;
        logic [BCN_W-1:0]   bcn;
    } header_t;

    typedef enum logic [1:0] {
        K_IDLE,
        K_HEAD,
        K_FILL,
        K_DATA
    } kind_e;

    function automatic logic [CAP_W-1:0] cap_next(input logic [CAP_W-1:0] c);
        return c + 1'b1;
    endfunction

endpackage

// File: rtl/ofmt_align_line.sv
module ofmt_align_line
    import ofmt_pkg::*;
#(
    parameter int MAX_DLY = 3,
    localparam int SEL_W  = $clog2(MAX_DLY + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  sample_t          smp_i,
    input  logic [SEL_W-1:0] sel_i,
    output sample_t          tap_o
);

    sample_t stg_q [1:MAX_DLY];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 1; i <= MAX_DLY; i++) stg_q[i] <= '0;
        end else begin
            stg_q[1] <= smp_i;
            for (int i = 2; i <= MAX_DLY; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    always_comb begin
        tap_o = smp_i;
        for (int i = 1; i <= MAX_DLY; i++) begin
            if (int'(sel_i) == i) tap_o = stg_q[i];
        end
    end

    // Delay of one: the tap equals the input seen one cycle earlier.
    AST_TAP_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (int'(sel_i) == 1) |=> ((int'(sel_i) != 1) || (tap_o == $past(smp_i)))); // R5

endmodule

// File: rtl/ofmt_bunch_ctr.sv
module ofmt_bunch_ctr
    import ofmt_pkg::*;
#(
    parameter int ORBIT_LEN = 3564
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             strobe_i,
    output logic [BCN_W-1:0] cnt_o,
    output logic             armed_o,
    output logic             err_o
);

    localparam logic [BCN_W-1:0] LAST = BCN_W'(ORBIT_LEN - 1);

    logic [BCN_W-1:0] cnt_q;
    logic             armed_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (strobe_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign cnt_o   = cnt_q;
    assign armed_o = armed_q;
    assign err_o   = strobe_i && armed_q && (cnt_q != LAST);

    AST_BCN_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        !strobe_i |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6
    AST_BCN_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_i |=> (cnt_q == '0 && armed_q)); // R6
    AST_NO_FIRST_ERR: assert property (@(posedge clk_i) disable iff (rst_i)
        !armed_q |-> !err_o); // R6

endmodule

// File: rtl/ofmt_cap_check.sv
module ofmt_cap_check
    import ofmt_pkg::*;
#(
    parameter int MAX_DLY = 3,
    localparam int HOLD   = MAX_DLY + 1,
    localparam int HOLD_W = $clog2(HOLD + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             strobe_i,
    input  logic             run_i,
    input  logic [CAP_W-1:0] cap_a_i,
    input  logic [CAP_W-1:0] cap_b_i,
    output logic             flag_o
);

    logic [CAP_W-1:0]  prev_q;
    logic [HOLD_W-1:0] hold_q;
    logic              sticky_q;
    logic              active, pair_bad, seq_bad, det;

    always_comb begin
        active   = run_i && (hold_q == '0);
        pair_bad = (cap_a_i != cap_b_i);
        seq_bad  = (cap_a_i != cap_next(prev_q));
        det      = active && (pair_bad || seq_bad);
        flag_o   = sticky_q || det;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q   <= '0;
            hold_q   <= '0;
            sticky_q <= 1'b0;
        end else begin
            prev_q <= cap_a_i;
            if (strobe_i)            hold_q <= HOLD_W'(HOLD);
            else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
            if (strobe_i)            sticky_q <= 1'b0;
            else if (det)            sticky_q <= 1'b1;
        end
    end

    AST_PAIR_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && hold_q == '0 && !strobe_i && cap_a_i != cap_b_i) |=> sticky_q); // R7
    AST_SEQ_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && hold_q == '0 && !strobe_i && cap_a_i != cap_next(prev_q)) |=> sticky_q); // R8
    AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |-> !sticky_q); // R9
    AST_CLEAR_ON_HDR: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_i |=> !sticky_q); // R10

endmodule

// File: rtl/orbit_formatter.sv
module orbit_formatter
    import ofmt_pkg::*;
#(
    parameter int ORBIT_LEN = 3564,
    parameter int FILL_LEN  = 69,
    parameter int MAX_DLY   = 3,
    localparam int SEL_W    = $clog2(MAX_DLY + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bc0_i,
    input  logic [1:0]        a_exp_i,
    input  logic [4:0]        a_mant_i,
    input  logic [1:0]        a_cap_i,
    input  logic [1:0]        b_exp_i,
    input  logic [4:0]        b_mant_i,
    input  logic [1:0]        b_cap_i,
    input  logic [SEL_W-1:0]  a_dly_i,
    input  logic [SEL_W-1:0]  b_dly_i,
    output logic [17:0]       tx_data_o,
    output logic              tx_send_o,
    output logic              dig_rst_o
);

    localparam int NCH    = 2;
    localparam int FILL_W = $clog2(FILL_LEN + 1);

    sample_t          raw [NCH];
    sample_t          tap [NCH];
    logic [SEL_W-1:0] sel [NCH];

    assign raw[0] = '{expo: a_exp_i, mant: a_mant_i, cap: a_cap_i};
    assign raw[1] = '{expo: b_exp_i, mant: b_mant_i, cap: b_cap_i};
    assign sel[0] = a_dly_i;
    assign sel[1] = b_dly_i;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        ofmt_align_line #(.MAX_DLY(MAX_DLY)) u_line (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .smp_i (raw[ch]),
            .sel_i (sel[ch]),
            .tap_o (tap[ch])
        );
    end

    logic [BCN_W-1:0] bcn;
    logic             run;
    logic             bcn_err;
    logic             cap_flag;

    ofmt_bunch_ctr #(.ORBIT_LEN(ORBIT_LEN)) u_bcn (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .strobe_i (bc0_i),
        .cnt_o    (bcn),
        .armed_o  (run),
        .err_o    (bcn_err)
    );

    ofmt_cap_check #(.MAX_DLY(MAX_DLY)) u_cap (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .strobe_i (bc0_i),
        .run_i    (run),
        .cap_a_i  (tap[0].cap),
        .cap_b_i  (tap[1].cap),
        .flag_o   (cap_flag)
    );

    logic [FILL_W-1:0] fill_left_q;
    kind_e             kind;
    header_t           hdr;
    logic [WORD_W-1:0] word_d;
    logic [WORD_W-1:0] data_q;
    logic              send_q, drst_q;

    always_comb begin
        if (bc0_i)                    kind = K_HEAD;
        else if (!run)                kind = K_IDLE;
        else if (fill_left_q != '0)   kind = K_FILL;
        else                          kind = K_DATA;

        hdr = '{cap_err: cap_flag, bcn_err: bcn_err, spare: '0, bcn: bcn};

        unique case (kind)
            K_HEAD:  word_d = hdr;
            K_FILL:  word_d = '1;
            K_DATA:  word_d = {tap[0], tap[1]};
            default: word_d = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fill_left_q <= '0;
            data_q      <= '0;
            send_q      <= 1'b0;
            drst_q      <= 1'b0;
        end else begin
            data_q <= word_d;
            send_q <= (kind != K_IDLE);
            drst_q <= bc0_i;
            if (bc0_i)                   fill_left_q <= FILL_W'(FILL_LEN);
            else if (fill_left_q != '0)  fill_left_q <= fill_left_q - 1'b1;
        end
    end

    assign tx_data_o = data_q;
    assign tx_send_o = send_q;
    assign dig_rst_o = drst_q;

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (!run && !bc0_i) |=> (!tx_send_o && tx_data_o == '0)); // R1
    AST_HDR_ON_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        bc0_i |=> (tx_send_o && dig_rst_o && tx_data_o[15:12] == '0)); // R2
    AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !bc0_i |=> !dig_rst_o); // R2
    AST_FILL_ONES: assert property (@(posedge clk_i) disable iff (rst_i)
        (run && !bc0_i && fill_left_q != '0) |=> (tx_data_o == '1)); // R3
    AST_SEND_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_send_o |=> tx_send_o); // R11

endmodule

// File: tb/orbit_formatter_test.sv
module orbit_formatter_test;

    localparam int OL = 24;
    localparam int FL = 4;
    localparam int MD = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bc0 = 1'b0;
    logic [1:0]  a_exp = '0, b_exp = '0, a_cap = '0, b_cap = '0;
    logic [4:0]  a_mant = '0, b_mant = '0;
    logic [1:0]  a_dly = '0, b_dly = '0;
    logic [17:0] tx_data;
    logic        tx_send, dig_rst;

    int checks = 0;
    int errors = 0;
    int n = 0;
    int da = 0, db = 0;

    always #10 clk = ~clk;

    orbit_formatter #(.ORBIT_LEN(OL), .FILL_LEN(FL), .MAX_DLY(MD)) uut (
        .clk_i(clk), .rst_i(rst), .bc0_i(bc0),
        .a_exp_i(a_exp), .a_mant_i(a_mant), .a_cap_i(a_cap),
        .b_exp_i(b_exp), .b_mant_i(b_mant), .b_cap_i(b_cap),
        .a_dly_i(a_dly), .b_dly_i(b_dly),
        .tx_data_o(tx_data), .tx_send_o(tx_send), .dig_rst_o(dig_rst)
    );

    function automatic logic [8:0] gen_a(input int t);
        logic [1:0] e = 2'((t / 4) % 4);
        logic [4:0] m = 5'((t * 5 + 3) % 32);
        logic [1:0] c = 2'(t % 4);
        return {e, m, c};
    endfunction

    function automatic logic [8:0] gen_b(input int t);
        logic [1:0] e = 2'((t / 8) % 4);
        logic [4:0] m = 5'((t * 11 + 7) % 32);
        logic [1:0] c = 2'(t % 4);
        return {e, m, c};
    endfunction

    function automatic logic [17:0] hdr(input logic cf, input logic bf, input int cnt);
        return {cf, bf, 4'b0000, 12'(cnt)};
    endfunction

    task automatic check(input logic ok, input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at edge %0d: actual %h expected %h", req, n, act, exp);
        end
    endtask

    // cm: 0 clean, 1 flip B capacitor ID, 2 both IDs jump forward by 2
    task automatic tick(input logic b0, input int cm);
        int t = n + 1;
        logic [8:0] sa = gen_a(t + da);
        logic [8:0] sb = gen_b(t + db);
        if (cm == 1) sb[1:0] = sb[1:0] ^ 2'b01;
        if (cm == 2) begin
            sa[1:0] = 2'(t + 2);
            sb[1:0] = 2'(t + 2);
        end
        bc0 = b0;
        {a_exp, a_mant, a_cap} = sa;
        {b_exp, b_mant, b_cap} = sb;
        a_dly = 2'(da);
        b_dly = 2'(db);
        @(posedge clk);
        n++;
        #5;
    endtask

    task automatic run_slots(input int len, input logic chk_data, input int bad_slot, input int cm);
        for (int j = 1; j <= len; j++) begin
            tick(1'b0, (j == bad_slot) ? cm : 0);
            if (j <= FL) begin
                check(tx_data == 18'h3FFFF && tx_send, "R3 fill", tx_data, 18'h3FFFF);
            end else if (chk_data) begin
                check(tx_data == {gen_a(n), gen_b(n)}, "R4 R5 data", tx_data, {gen_a(n), gen_b(n)});
            end
            check(tx_send && !dig_rst, "R11 R2 send/reset", {16'b0, tx_send, dig_rst}, 18'b10);
        end
    endtask

    task automatic header(input logic cf, input logic bf, input int cnt, input int cm);
        tick(1'b1, cm);
        check(tx_data == hdr(cf, bf, cnt), "R2 R6 R10 header", tx_data, hdr(cf, bf, cnt));
        check(tx_send && dig_rst, "R2 header strobes", {16'b0, tx_send, dig_rst}, 18'b11);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) tick(1'b0, 0);
        check(tx_data == '0 && !tx_send && !dig_rst, "R1 reset state", tx_data, '0);
        rst = 1'b0;

        // R1 R9: idle before the first strobe, injected mismatch ignored
        for (int i = 0; i < 8; i++) begin
            tick(1'b0, (i == 4) ? 1 : 0);
            check(!tx_send && tx_data == '0 && !dig_rst, "R1 idle", tx_data, '0);
        end

        // first strobe: count unknown, flags must be clear (R6 R9)
        tick(1'b1, 0);
        check(tx_data[17:12] == '0, "R6 R9 first header flags", tx_data, {6'b0, tx_data[11:0]});
        check(tx_send && dig_rst, "R2 first header strobes", {16'b0, tx_send, dig_rst}, 18'b11);
        run_slots(OL - 1, 1'b1, 0, 0);
        header(1'b0, 1'b0, OL - 1, 0);

        // R5: sweep all delay pairs
        for (int x = 0; x <= MD; x++) begin
            for (int y = 0; y <= MD; y++) begin
                da = x;
                db = y;
                for (int k = 0; k < 4; k++) tick(1'b0, 0);
                tick(1'b1, 0);
                run_slots(OL - 1, 1'b1, 0, 0);
                header(1'b0, 1'b0, OL - 1, 0);
            end
        end
        da = 0;
        db = 0;
        for (int k = 0; k < 4; k++) tick(1'b0, 0);
        tick(1'b1, 0);
        run_slots(OL - 1, 1'b1, 0, 0);
        header(1'b0, 1'b0, OL - 1, 0);

        // R6: short orbit, then a normal one
        run_slots(9, 1'b1, 0, 0);
        header(1'b0, 1'b1, 9, 0);
        run_slots(OL - 1, 1'b1, 0, 0);
        header(1'b0, 1'b0, OL - 1, 0);

        // R6 R11: long orbit keeps sending data words
        run_slots(OL + 2, 1'b1, 0, 0);
        header(1'b0, 1'b1, OL + 2, 0);
        run_slots(OL - 1, 1'b1, 0, 0);
        header(1'b0, 1'b0, OL - 1, 0);

        // R7: channel mismatch mid-orbit, R10: cleared afterwards
        run_slots(OL - 1, 1'b0, 12, 1);
        header(1'b1, 1'b0, OL - 1, 0);
        run_slots(OL - 1, 1'b1, 0, 0);
        header(1'b0, 1'b0, OL - 1, 0);

        // R8: sequence break with both channels agreeing
        run_slots(OL - 1, 1'b0, 12, 2);
        header(1'b1, 1'b0, OL - 1, 0);

        // R9: mismatch inside the hold window is ignored
        run_slots(OL - 1, 1'b0, 2, 1);
        header(1'b0, 1'b0, OL - 1, 0);

        // R10: error in the strobe cycle lands in that header, then clears
        run_slots(OL - 1, 1'b1, 0, 0);
        header(1'b1, 1'b0, OL - 1, 1);
        run_slots(OL - 1, 1'b0, 0, 0);
        header(1'b0, 1'b0, OL - 1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule